// File: doc/BRIEF.md
# Scheduled Time-Triggered Pulse Generator

This block emits a single output pulse at an absolute moment on a free-running reference timebase. The timebase has two parts: a seconds count and a count of reference clock cycles within the current second. A system-side agent loads the trigger moment with a one-cycle strobe and can set a flag that asks for the pulse at once, skipping the time comparison. A ready output tells the agent when another trigger may be loaded.

The trigger is held in system-domain registers and carried into the reference domain by a toggle handshake. A second toggle travels back to clear the busy state. The reference side arms the trigger and compares it with the timebase on every reference edge. On an exact match it drives the output high for a fixed number of reference cycles. A trigger is dropped, and no pulse is made, in three cases: its moment has already passed, its cycle field can never occur, or the timebase loses validity. While the timebase is invalid, the block keeps ready high and ignores loads.

Top module: `sched_pulse_gen`

## Requirements
- R1: After reset, `trig_ready_o` is 1 and `pulse_o` is 0.
- R2: A load (`trig_load_i` = 1 on a system edge, with `trig_ready_o` = 1 and a valid timebase) is accepted, and `trig_ready_o` goes to 0 right after that edge.
- R3: A scheduled trigger (`trig_now_i` = 0) fires on the reference edge that samples `tb_sec_i` and `tb_cyc_i` both equal to the trigger. `pulse_o` is high from that edge on. Comparison starts on the edge after the trigger reaches the reference domain. A matching cycle count with different seconds does not fire.
- R4: A trigger loaded with `trig_now_i` = 1 makes `pulse_o` rise on the reference edge that takes the trigger into the reference domain, whatever the timebase value. That edge is the third reference edge after the accepting system edge, counting two synchronizer stages and one edge-detect stage.
- R5: `pulse_o` stays high for exactly `PULSE_LEN` reference cycles (default 4), then returns to 0.
- R6: The return acknowledge is sent on the reference edge where the pulse ends. `trig_ready_o` returns to 1 two system edges later.
- R7: If an armed trigger compares earlier than the sampled timebase ({seconds, cycles} as one unsigned number), it is dropped without a pulse and ready returns as in R6.
- R8: A scheduled trigger whose cycle field is `REF_CLK_HZ` or more is dropped at capture, and no pulse is made.
- R9: While `tb_valid_i` is 0, `trig_ready_o` stays 1, loads are ignored, and no pulse starts.
- R10: If `tb_valid_i` falls while a trigger is armed, the trigger is dropped on that reference edge.
- R11: A load strobe while `trig_ready_o` is 0 is ignored.
- R12: After acceptance, changes on the trigger inputs do not alter the pending trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys_i | input | 1 | System-domain clock |
| clk_ref_i | input | 1 | Reference-domain clock |
| rst_i | input | 1 | Synchronous active-high reset, seen by both domains |
| trig_sec_i | input | 40 | Trigger seconds |
| trig_cyc_i | input | 28 | Trigger cycle count within the second |
| trig_now_i | input | 1 | 1: fire at once and ignore the trigger time |
| trig_load_i | input | 1 | One-cycle load strobe (system domain) |
| trig_ready_o | output | 1 | 1: a new trigger may be loaded (system domain) |
| tb_valid_i | input | 1 | Timebase valid (reference domain) |
| tb_sec_i | input | 40 | Timebase seconds (reference domain) |
| tb_cyc_i | input | 28 | Timebase cycle count (reference domain) |
| pulse_o | output | 1 | Output pulse (reference domain) |

## Verification
The hardest situation to reach is loss of timebase validity while a trigger sits armed, because validity, the handshake and the ready path all have different latencies. The stimulus arms a trigger well in the future and drops validity for two cycles. It then restores validity and expects ready back with no pulse. A further test programs a matching cycle count under the wrong second, and another jumps the timebase just before a second boundary, so that a trigger on cycle 3 of the next second must be found across the wrap.

// File: rtl/spg_pkg.sv
`timescale 1ns/1ps
package spg_pkg;

    localparam int SPG_SEC_W = 40;
    localparam int SPG_CYC_W = 28;

    typedef struct packed {
        logic [SPG_SEC_W-1:0] sec;
        logic [SPG_CYC_W-1:0] cyc;
    } spg_time_t;

    typedef struct packed {
        spg_time_t at;
        logic      now;
    } spg_trig_t;

    typedef enum logic [1:0] {
        SPG_IDLE  = 2'd0,
        SPG_ARMED = 2'd1,
        SPG_FIRE  = 2'd2
    } spg_state_e;

    // true when moment a lies strictly after moment b
    function automatic logic spg_after(input spg_time_t a, input spg_time_t b);
        return {a.sec, a.cyc} > {b.sec, b.cyc};
    endfunction

    function automatic logic spg_same(input spg_time_t a, input spg_time_t b);
        return (a.sec == b.sec) && (a.cyc == b.cyc);
    endfunction

endpackage

// File: rtl/spg_sync.sv
`timescale 1ns/1ps
module spg_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain[0] <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spg_sys_side.sv
`timescale 1ns/1ps
module spg_sys_side import spg_pkg::*; (
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  spg_trig_t trig_in,
    input  logic      valid_s,
    input  logic      ack_s,
    output logic      req_tgl,
    output spg_trig_t held,
    output logic      busy,
    output logic      ready
);
    logic accept;

    // busy while our request toggle has not been echoed back
    assign busy   = req_tgl ^ ack_s;
    assign accept = load & ~busy & valid_s;
    assign ready  = ~busy | ~valid_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_tgl <= 1'b0;
            held    <= '0;
        end else if (accept) begin
            req_tgl <= ~req_tgl;
            held    <= trig_in;
        end
    end
endmodule

// File: rtl/spg_ref_core.sv
`timescale 1ns/1ps
module spg_ref_core import spg_pkg::*; #(
    parameter int REF_CLK_HZ = 125000000,
    parameter int PULSE_LEN  = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req_s,
    input  spg_trig_t held,
    input  logic      tb_valid,
    input  spg_time_t tb_now,
    output logic      ack_tgl,
    output logic      pulse
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [SPG_CYC_W-1:0] CYC_LAST = SPG_CYC_W'(REF_CLK_HZ - 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    spg_state_e       state_q, state_d;
    spg_time_t        armed_q, armed_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             req_seen_q;
    logic             new_req;
    logic             ack_flip;

    assign new_req = req_s ^ req_seen_q;

    always_comb begin
        state_d  = state_q;
        armed_d  = armed_q;
        cnt_d    = cnt_q;
        ack_flip = 1'b0;
        unique case (state_q)
            SPG_IDLE: begin
                if (new_req) begin
                    armed_d = held.at;
                    if (!tb_valid) begin
                        ack_flip = 1'b1;
                    end else if (held.now) begin
                        cnt_d   = CNT_LOAD;
                        state_d = SPG_FIRE;
                    end else if (held.at.cyc > CYC_LAST) begin
                        ack_flip = 1'b1;
                    end else begin
                        state_d = SPG_ARMED;
                    end
                end
            end
            SPG_ARMED: begin
                if (!tb_valid) begin
                    ack_flip = 1'b1;
                    state_d  = SPG_IDLE;
                end else if (spg_same(tb_now, armed_q)) begin
                    cnt_d   = CNT_LOAD;
                    state_d = SPG_FIRE;
                end else if (spg_after(tb_now, armed_q)) begin
                    ack_flip = 1'b1;
                    state_d  = SPG_IDLE;
                end
            end
            SPG_FIRE: begin
                cnt_d = cnt_q - CNT_ONE;
                if (cnt_q == CNT_ONE) begin
                    ack_flip = 1'b1;
                    state_d  = SPG_IDLE;
                end
            end
            default: state_d = SPG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SPG_IDLE;
            armed_q    <= '0;
            cnt_q      <= '0;
            req_seen_q <= 1'b0;
            ack_tgl    <= 1'b0;
        end else begin
            state_q    <= state_d;
            armed_q    <= armed_d;
            cnt_q      <= cnt_d;
            req_seen_q <= req_s;
            if (ack_flip) ack_tgl <= ~ack_tgl;
        end
    end

    assign pulse = (state_q == SPG_FIRE);
endmodule

// File: rtl/sched_pulse_gen.sv
`timescale 1ns/1ps
module sched_pulse_gen import spg_pkg::*; #(
    parameter int REF_CLK_HZ  = 125000000,
    parameter int PULSE_LEN   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_sys_i,
    input  logic                 clk_ref_i,
    input  logic                 rst_i,
    input  logic [SPG_SEC_W-1:0] trig_sec_i,
    input  logic [SPG_CYC_W-1:0] trig_cyc_i,
    input  logic                 trig_now_i,
    input  logic                 trig_load_i,
    output logic                 trig_ready_o,
    input  logic                 tb_valid_i,
    input  logic [SPG_SEC_W-1:0] tb_sec_i,
    input  logic [SPG_CYC_W-1:0] tb_cyc_i,
    output logic                 pulse_o
);
    spg_trig_t trig_in;
    spg_trig_t held_trig;
    spg_time_t tb_now;
    logic      req_tgl, req_s;
    logic      ack_tgl, ack_s;
    logic      valid_s;
    logic      sys_busy;

    assign trig_in = '{at: '{sec: trig_sec_i, cyc: trig_cyc_i}, now: trig_now_i};
    assign tb_now  = '{sec: tb_sec_i, cyc: tb_cyc_i};

    spg_sync #(.STAGES(SYNC_STAGES), .W(1)) u_valid_sync (
        .clk(clk_sys_i), .rst(rst_i), .d(tb_valid_i), .q(valid_s));

    spg_sync #(.STAGES(SYNC_STAGES), .W(1)) u_ack_sync (
        .clk(clk_sys_i), .rst(rst_i), .d(ack_tgl), .q(ack_s));

    spg_sync #(.STAGES(SYNC_STAGES), .W(1)) u_req_sync (
        .clk(clk_ref_i), .rst(rst_i), .d(req_tgl), .q(req_s));

    spg_sys_side u_sys (
        .clk     (clk_sys_i),
        .rst     (rst_i),
        .load    (trig_load_i),
        .trig_in (trig_in),
        .valid_s (valid_s),
        .ack_s   (ack_s),
        .req_tgl (req_tgl),
        .held    (held_trig),
        .busy    (sys_busy),
        .ready   (trig_ready_o)
    );

    spg_ref_core #(.REF_CLK_HZ(REF_CLK_HZ), .PULSE_LEN(PULSE_LEN)) u_ref (
        .clk      (clk_ref_i),
        .rst      (rst_i),
        .req_s    (req_s),
        .held     (held_trig),
        .tb_valid (tb_valid_i),
        .tb_now   (tb_now),
        .ack_tgl  (ack_tgl),
        .pulse    (pulse_o)
    );
endmodule

// File: rtl/spg_chk.sv
`timescale 1ns/1ps
module spg_chk import spg_pkg::*; #(
    parameter int PULSE_LEN = 4
) (
    input logic      clk_ref,
    input logic      clk_sys,
    input logic      rst,
    input logic      pulse,
    input logic      ready,
    input logic      valid,
    input logic      busy,
    input spg_trig_t held
);
    int run_len;
    int inv_len;

    always_ff @(posedge clk_ref) begin
        if (rst)        run_len <= 0;
        else if (pulse) run_len <= run_len + 1;
        else            run_len <= 0;
    end

    always_ff @(posedge clk_sys) begin
        if (rst)                    inv_len <= 0;
        else if (valid)             inv_len <= 0;
        else if (inv_len < 3)       inv_len <= inv_len + 1;
    end

    // R5: never longer than the set width
    p_width_cap_r5: assert property (@(posedge clk_ref) disable iff (rst)
        pulse |-> run_len < PULSE_LEN);

    // R5: every pulse that ends has the full width
    p_width_full_r5: assert property (@(posedge clk_ref) disable iff (rst)
        (!pulse && run_len != 0) |-> run_len == PULSE_LEN);

    // R9: a pulse only starts from a valid timebase sample
    p_start_valid_r9: assert property (@(posedge clk_ref) disable iff (rst)
        $rose(pulse) |-> $past(valid));

    // R9: ready is held high once invalidity has crossed over
    p_ready_invalid_r9: assert property (@(posedge clk_sys) disable iff (rst)
        (inv_len >= 2) |-> ready);

    // R12: the trigger register does not move while a request is pending
    p_held_stable_r12: assert property (@(posedge clk_sys) disable iff (rst)
        (busy && $past(busy)) |-> $stable(held));
endmodule

bind sched_pulse_gen spg_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk_ref (clk_ref_i),
    .clk_sys (clk_sys_i),
    .rst     (rst_i),
    .pulse   (pulse_o),
    .ready   (trig_ready_o),
    .valid   (tb_valid_i),
    .busy    (sys_busy),
    .held    (held_trig)
);

// File: tb/sched_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module sched_pulse_gen_tb_top;
    localparam longint RATE = 125000000;
    localparam int     PLEN = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [39:0] trig_sec = '0;
    logic [27:0] trig_cyc = '0;
    logic        trig_now = 1'b0;
    logic        trig_load = 1'b0;
    logic        trig_ready;
    logic        tb_valid = 1'b0;
    logic [39:0] tbs = 40'd5;
    logic [27:0] tbc = '0;
    logic        pulse;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string cur_req  = "R1";

    always #4 clk = ~clk;

    sched_pulse_gen #(.REF_CLK_HZ(125000000), .PULSE_LEN(PLEN), .SYNC_STAGES(2)) dut_i (
        .clk_sys_i(clk), .clk_ref_i(clk), .rst_i(rst),
        .trig_sec_i(trig_sec), .trig_cyc_i(trig_cyc), .trig_now_i(trig_now),
        .trig_load_i(trig_load), .trig_ready_o(trig_ready),
        .tb_valid_i(tb_valid), .tb_sec_i(tbs), .tb_cyc_i(tbc), .pulse_o(pulse));

    function automatic logic [67:0] t_add(input logic [39:0] s, input logic [27:0] c, input int d);
        longint cc = longint'(c) + d;
        logic [39:0] ss = s;
        while (cc >= RATE) begin cc -= RATE; ss++; end
        while (cc < 0)     begin cc += RATE; ss--; end
        return {ss, cc[27:0]};
    endfunction

    task automatic check(input string req, input string what, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    // behavioural reference model, stepped once per clock
    int          n = 0, pl = 0, cap_e = 0, ack_e = -10, rises = 0;
    bit          busy = 0, armed = 0, pend = 0, mnow = 0, va = 0, vb = 0, prev_p = 0;
    logic [67:0] mt = '0;
    bit          jump_req = 0;
    logic [67:0] jump_val = '0;

    always @(negedge clk) begin
        bit          v;
        logic [67:0] cur;
        logic [67:0] nxt;
        n++;
        cur = {tbs, tbc};
        if (rst) begin
            pl = 0; busy = 0; armed = 0; pend = 0; ack_e = -10; va = 0; vb = 0;
        end else begin
            v = tb_valid;
            if (pl > 0) begin pl--; if (pl == 0) ack_e = n; end
            if (pend && n == cap_e) begin
                pend = 0;
                if (!v)                       ack_e = n;
                else if (mnow)                pl = PLEN;
                else if (longint'(mt[27:0]) >= RATE) ack_e = n;
                else                          armed = 1;
            end else if (armed) begin
                if (!v)             begin armed = 0; ack_e = n; end
                else if (cur == mt) begin armed = 0; pl = PLEN; end
                else if (cur > mt)  begin armed = 0; ack_e = n; end
            end
            if (trig_load && !busy && vb) begin
                busy = 1; pend = 1; cap_e = n + 3;
                mt = {trig_sec, trig_cyc}; mnow = trig_now;
            end else if (busy && n == ack_e + 2) begin
                busy = 0;
            end
            vb = va; va = v;
        end
        check(cur_req, "pulse_o", pulse, pl > 0);
        check(cur_req, "trig_ready_o", trig_ready, !busy || !vb);
        if (pulse && !prev_p) rises++;
        prev_p = pulse;
        if (jump_req) begin
            {tbs, tbc} = jump_val; jump_req = 0;
        end else begin
            nxt = t_add(tbs, tbc, 1);
            {tbs, tbc} = nxt;
        end
    end

    task automatic wait_n(input int k);
        repeat (k) @(negedge clk);
        #1;
    endtask

    task automatic load(input logic [39:0] s, input logic [27:0] c, input logic now);
        @(negedge clk); #1;
        trig_sec = s; trig_cyc = c; trig_now = now; trig_load = 1'b1;
        @(negedge clk); #1;
        trig_load = 1'b0;
    endtask

    task automatic jump(input logic [67:0] t);
        @(negedge clk); #1;
        jump_val = t; jump_req = 1;
    endtask

    task automatic expect_rises(input string req, input int base, input int add);
        n_checks++;
        if (rises != base + add) begin
            n_fail++;
            $display("FAIL %s pulse count got %0d expected %0d", req, rises - base, add);
        end
    endtask

    initial begin
        int          base;
        logic [67:0] t;
        wait_n(4);
        rst = 1'b0;
        wait_n(1);
        cur_req = "R1";
        check("R1", "reset ready", trig_ready, 1'b1);
        check("R1", "reset pulse", pulse, 1'b0);

        tb_valid = 1'b1;
        wait_n(5);

        // scheduled fire, width, ready return
        cur_req = "R2/R3/R5/R6"; base = rises;
        t = t_add(tbs, tbc, 20);
        load(t[67:28], t[27:0], 1'b0);
        check("R2", "ready after load", trig_ready, 1'b0);
        wait_n(40);
        expect_rises("R3", base, 1);
        check("R6", "ready back", trig_ready, 1'b1);

        // inputs changed after load, and a second load while busy
        cur_req = "R11/R12"; base = rises;
        t = t_add(tbs, tbc, 30);
        load(t[67:28], t[27:0], 1'b0);
        trig_sec = '0; trig_cyc = 28'd7; trig_now = 1'b1;
        wait_n(3);
        t = t_add(tbs, tbc, 8);
        load(t[67:28], t[27:0], 1'b1);
        wait_n(50);
        expect_rises("R11", base, 1);

        // immediate fire
        cur_req = "R4/R5"; base = rises;
        load(40'd0, 28'd0, 1'b1);
        wait_n(20);
        expect_rises("R4", base, 1);
        check("R6", "ready after immediate", trig_ready, 1'b1);

        // late trigger
        cur_req = "R7"; base = rises;
        jump({40'd7, 28'd1000});
        wait_n(2);
        load(40'd7, 28'd500, 1'b0);
        wait_n(20);
        expect_rises("R7", base, 0);
        check("R7", "ready after late drop", trig_ready, 1'b1);

        // cycle field out of range
        cur_req = "R8"; base = rises;
        load(tbs + 40'd1, 28'(RATE), 1'b0);
        wait_n(20);
        expect_rises("R8", base, 0);

        // second boundary crossing
        cur_req = "R3"; base = rises;
        jump({40'd9, 28'(RATE - 10)});
        wait_n(2);
        load(40'd10, 28'd3, 1'b0);
        wait_n(40);
        expect_rises("R3", base, 1);

        // cycle count equal but seconds different
        cur_req = "R3"; base = rises;
        t = {tbs + 40'd1, tbc + 28'd15};
        load(t[67:28], t[27:0], 1'b0);
        wait_n(30);
        expect_rises("R3", base, 0);
        jump({t[67:28], t[27:0] - 28'd5});
        wait_n(20);
        expect_rises("R3", base, 1);

        // invalid timebase
        cur_req = "R9"; base = rises;
        tb_valid = 1'b0;
        wait_n(5);
        check("R9", "ready while invalid", trig_ready, 1'b1);
        load(40'd0, 28'd0, 1'b1);
        t = t_add(tbs, tbc, 6);
        load(t[67:28], t[27:0], 1'b0);
        wait_n(20);
        expect_rises("R9", base, 0);

        // validity lost while armed
        cur_req = "R10"; base = rises;
        tb_valid = 1'b1;
        wait_n(5);
        load(tbs + 40'd2, 28'd0, 1'b0);
        wait_n(10);
        check("R10", "busy while armed", trig_ready, 1'b0);
        tb_valid = 1'b0;
        wait_n(2);
        tb_valid = 1'b1;
        wait_n(10);
        check("R10", "ready after drop", trig_ready, 1'b1);
        expect_rises("R10", base, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule